// File: doc/BRIEF.md
# Two-Thread Memory-Op Slot Allocator with Tag-Only Overflow

This block manages slot allocation for a load-ordering or store-ordering queue shared by two hardware threads. It does not keep addresses or data. It tracks, for each thread, which in-flight memory operations hold a real queue slot and which hold only a tag-only overflow entry. It also works out when each operation may issue.

At dispatch a thread asks for zero, one or two slots. Each granted operation receives a per-thread sequence tag. The tag is marked real (with the physical slot index) or virtual (with its overflow-pool index). When the thread has no room left in either pool, the dispatch stalls.

Operations leave from the oldest end of each thread:
- In load flavour, an operation leaves at completion.
- In store flavour, an operation leaves only after it has completed and a sent-to-cache event has been seen.

Each departure promotes the oldest virtual operation of that thread to a real slot. A query port turns any live tag into its present real/virtual state and slot.

A flush cuts a thread back to a given sequence number. A mode input gives all real slots to thread 0.

Top module: `mq_slot_alloc`

## Requirements
- R1: After reset, every thread is empty: no queried tag is live, and a legal dispatch of 1 or 2 operations is not stalled.
- R2: A granted operation at position p (0 = oldest live) of thread t is real when p is below the thread's real capacity. The real capacity is 16 per thread in two-thread mode, and 32 for thread 0 in single-thread mode. Its slot is {t, seq[3:0]} in two-thread mode and seq[4:0] in single-thread mode, where seq is its 6-bit sequence tag.
- R3: An operation whose position is at or beyond the real capacity is granted as virtual (dsp_virt=1), with slot value {0, seq[3:0]}. Each thread has 16 virtual entries.
- R4: A dispatch stalls when any of these holds:
  - the count is 3;
  - the thread's occupancy plus the count exceeds the real capacity plus 16;
  - the thread is being flushed in the same cycle.

  A stalled dispatch grants nothing.
- R5: Tags are handed out in consecutive sequence order per thread, modulo 64. Entries leave strictly from the oldest end. In load flavour a completion of n operations frees the n oldest.
- R6: In store flavour an entry is freed only by a sent event on an already-completed oldest entry, one per cycle. A sent event with no completed entry pending changes nothing.
- R7: A queried live tag is issue-eligible exactly when it holds a real slot. Each freed entry promotes the oldest virtual entry of that thread, which then reports the real slot given by R2.
- R8: In single-thread mode, thread 0 owns all 32 real slots and any dispatch from thread 1 stalls.
- R9: A flush of thread t to sequence s frees every entry of t from s onward in one cycle, provided s lies between the oldest uncompleted entry and the tail. The next dispatch of t then starts at s. A flush outside that range is ignored.
- R10: The two threads have separate occupancy, so a full thread 0 does not stall a dispatch of thread 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_mode | input | 1 | 1 = single-thread mode (change only while empty) |
| dsp_req | input | 1 | Dispatch request |
| dsp_tid | input | 1 | Dispatching thread |
| dsp_cnt | input | 2 | Memory operations in the group (0 to 2) |
| dsp_stall | output | 1 | Group cannot be granted this cycle |
| dsp_ok | output | 2 | Per-operation grant |
| dsp_seq | output | 2x6 | Per-operation sequence tag |
| dsp_virt | output | 2 | Per-operation virtual mark |
| dsp_slot | output | 2x5 | Real slot, or virtual index |
| cmp_valid | input | 1 | Completion event |
| cmp_tid | input | 1 | Completing thread |
| cmp_cnt | input | 2 | Oldest operations completing (0 to 2) |
| snd_valid | input | 1 | Store sent to cache |
| snd_tid | input | 1 | Thread of the sent store |
| fl_valid | input | 1 | Flush request |
| fl_tid | input | 1 | Flushed thread |
| fl_seq | input | 6 | First sequence tag to discard |
| qry_tid | input | 1 | Thread of the queried tag |
| qry_seq | input | 6 | Queried sequence tag |
| qry_live | output | 1 | Tag is currently allocated |
| qry_issue_ok | output | 1 | Tag holds a real slot |
| qry_slot | output | 5 | Current slot or virtual index of the tag |

## Verification
The hardest states to reach are a thread whose virtual pool is partly filled while the promotion boundary moves, and, in store flavour, a gap between completion and the sent event. Random completion and sent rates alternate between a starving phase, which fills both pools up to stall, and a draining phase, which keeps promotions and out-of-range flushes happening. Directed sequences fill thread 0 exactly to the stall point and compare the two flavours across one completion. Both flavours take identical stimulus and are each checked against a bench model.

// File: rtl/mq_slot_pkg.sv
package mq_slot_pkg;
    localparam int TOTAL_REAL = 32;
    localparam int VIRT_PER_THR = 16;
    localparam int HALF_REAL = TOTAL_REAL / 2;
    localparam int SEQ_W = $clog2(TOTAL_REAL + VIRT_PER_THR);
    localparam int SLOT_W = $clog2(TOTAL_REAL);
    localparam int HALF_W = $clog2(HALF_REAL);
    localparam int VIDX_W = $clog2(VIRT_PER_THR);

    typedef logic [SEQ_W-1:0] seq_t;

    // head: oldest live, done: oldest not completed, tail: next to allocate
    typedef struct packed {
        seq_t head;
        seq_t done;
        seq_t tail;
    } ring_t;

    function automatic seq_t real_cap(input logic st, input logic tid);
        if (st) return tid ? seq_t'(0) : seq_t'(TOTAL_REAL);
        return seq_t'(HALF_REAL);
    endfunction
endpackage

// File: rtl/mq_tag_map.sv
module mq_tag_map
    import mq_slot_pkg::*;
(
    input  logic              st_mode,
    input  logic              tid,
    input  seq_t              seq,
    input  seq_t              head,
    input  seq_t              cap,
    output logic              in_cap,
    output logic [SLOT_W-1:0] slot
);
    seq_t pos;

    always_comb begin
        pos    = seq - head;
        in_cap = pos < cap;
        if (!in_cap)
            slot = SLOT_W'(seq[VIDX_W-1:0]);
        else if (st_mode)
            slot = seq[SLOT_W-1:0];
        else
            slot = {tid, seq[HALF_W-1:0]};
    end
endmodule

// File: rtl/mq_thread_ctl.sv
module mq_thread_ctl
    import mq_slot_pkg::*;
#(
    parameter bit STORE_MODE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  seq_t       limit,
    input  logic [1:0] add_cnt,
    input  logic [1:0] cmp_cnt,
    input  logic       snd,
    input  logic       fl,
    input  seq_t       fl_seq,
    output ring_t      ring,
    output seq_t       room
);
    ring_t nxt;
    seq_t  occ;
    logic  fl_ok;

    always_comb begin
        occ      = ring.tail - ring.head;
        room     = limit - occ;
        fl_ok    = fl && ((fl_seq - ring.done) <= (ring.tail - ring.done));
        nxt.done = ring.done + seq_t'(cmp_cnt);
        nxt.tail = fl_ok ? fl_seq : ring.tail + seq_t'(add_cnt);
    end

    generate
        if (STORE_MODE) begin : g_store
            always_comb
                nxt.head = ring.head + seq_t'(snd && (ring.done != ring.head));

            p_sent_idle_r6: assert property (@(posedge clk) disable iff (rst)
                (snd && ring.done == ring.head) |=> ring.head == $past(ring.head));
        end else begin : g_load
            always_comb nxt.head = nxt.done;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ring <= '0;
        else     ring <= nxt;
    end

    p_occ_bound_r4: assert property (@(posedge clk) disable iff (rst)
        occ <= limit);
    p_order_r5: assert property (@(posedge clk) disable iff (rst)
        (ring.done - ring.head) <= (ring.tail - ring.head));
    p_cmp_legal_r5: assert property (@(posedge clk) disable iff (rst)
        seq_t'(cmp_cnt) <= (ring.tail - ring.done));
    p_flush_cut_r9: assert property (@(posedge clk) disable iff (rst)
        fl_ok |=> ring.tail == $past(fl_seq));
endmodule

// File: rtl/mq_slot_alloc.sv
module mq_slot_alloc
    import mq_slot_pkg::*;
#(
    parameter bit STORE_MODE = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   st_mode,
    input  logic                   dsp_req,
    input  logic                   dsp_tid,
    input  logic [1:0]             dsp_cnt,
    output logic                   dsp_stall,
    output logic [1:0]             dsp_ok,
    output logic [1:0][SEQ_W-1:0]  dsp_seq,
    output logic [1:0]             dsp_virt,
    output logic [1:0][SLOT_W-1:0] dsp_slot,
    input  logic                   cmp_valid,
    input  logic                   cmp_tid,
    input  logic [1:0]             cmp_cnt,
    input  logic                   snd_valid,
    input  logic                   snd_tid,
    input  logic                   fl_valid,
    input  logic                   fl_tid,
    input  logic [SEQ_W-1:0]       fl_seq,
    input  logic                   qry_tid,
    input  logic [SEQ_W-1:0]       qry_seq,
    output logic                   qry_live,
    output logic                   qry_issue_ok,
    output logic [SLOT_W-1:0]      qry_slot
);
    ring_t rings [2];
    seq_t  rooms [2];
    logic  accept;
    logic  q_in_cap;

    always_comb begin
        dsp_stall = dsp_req && ((dsp_cnt == 2'd3)
                              || (st_mode && dsp_tid)
                              || (fl_valid && fl_tid == dsp_tid)
                              || (seq_t'(dsp_cnt) > rooms[dsp_tid]));
        accept = dsp_req && !dsp_stall;
    end

    generate
        for (genvar t = 0; t < 2; t++) begin : g_thr
            mq_thread_ctl #(.STORE_MODE(STORE_MODE)) u_ctl (
                .clk     (clk),
                .rst     (rst),
                .limit   (real_cap(st_mode, 1'(t)) + seq_t'(VIRT_PER_THR)),
                .add_cnt ((accept && dsp_tid == 1'(t)) ? dsp_cnt : 2'd0),
                .cmp_cnt ((cmp_valid && cmp_tid == 1'(t)) ? cmp_cnt : 2'd0),
                .snd     (snd_valid && snd_tid == 1'(t)),
                .fl      (fl_valid && fl_tid == 1'(t)),
                .fl_seq  (fl_seq),
                .ring    (rings[t]),
                .room    (rooms[t])
            );
        end

        for (genvar k = 0; k < 2; k++) begin : g_op
            logic op_in_cap;
            assign dsp_seq[k] = rings[dsp_tid].tail + seq_t'(k);
            mq_tag_map u_map (
                .st_mode (st_mode),
                .tid     (dsp_tid),
                .seq     (dsp_seq[k]),
                .head    (rings[dsp_tid].head),
                .cap     (real_cap(st_mode, dsp_tid)),
                .in_cap  (op_in_cap),
                .slot    (dsp_slot[k])
            );
            assign dsp_ok[k]   = accept && (2'(k) < dsp_cnt);
            assign dsp_virt[k] = !op_in_cap;
        end
    endgenerate

    mq_tag_map u_qmap (
        .st_mode (st_mode),
        .tid     (qry_tid),
        .seq     (qry_seq),
        .head    (rings[qry_tid].head),
        .cap     (real_cap(st_mode, qry_tid)),
        .in_cap  (q_in_cap),
        .slot    (qry_slot)
    );

    always_comb begin
        qry_live     = (qry_seq - rings[qry_tid].head) < (rings[qry_tid].tail - rings[qry_tid].head);
        qry_issue_ok = qry_live && q_in_cap;
    end

    p_stall_none_r4: assert property (@(posedge clk) disable iff (rst)
        dsp_stall |-> dsp_ok == 2'b00);
    p_issue_live_r7: assert property (@(posedge clk) disable iff (rst)
        qry_issue_ok |-> qry_live);
    p_st_thread1_r8: assert property (@(posedge clk) disable iff (rst)
        (st_mode && dsp_req && dsp_tid) |-> dsp_stall);
    p_grant_order_r5: assert property (@(posedge clk) disable iff (rst)
        (dsp_ok[1]) |-> dsp_ok[0]);
endmodule

// File: tb/mq_slot_alloc_bench.sv
module mq_slot_alloc_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, st_mode, dsp_req, dsp_tid, cmp_valid, cmp_tid, snd_valid, snd_tid;
    logic fl_valid, fl_tid, qry_tid;
    logic [1:0] dsp_cnt, cmp_cnt;
    logic [5:0] fl_seq, qry_seq;

    logic            o_stall [2];
    logic [1:0]      o_ok    [2];
    logic [1:0][5:0] o_seq   [2];
    logic [1:0]      o_virt  [2];
    logic [1:0][4:0] o_slot  [2];
    logic            o_live  [2];
    logic            o_iss   [2];
    logic [4:0]      o_qslot [2];

    mq_slot_alloc #(.STORE_MODE(1'b1)) u_mq_slot_alloc (
        .clk(clk), .rst(rst), .st_mode(st_mode), .dsp_req(dsp_req), .dsp_tid(dsp_tid),
        .dsp_cnt(dsp_cnt), .dsp_stall(o_stall[0]), .dsp_ok(o_ok[0]), .dsp_seq(o_seq[0]),
        .dsp_virt(o_virt[0]), .dsp_slot(o_slot[0]), .cmp_valid(cmp_valid), .cmp_tid(cmp_tid),
        .cmp_cnt(cmp_cnt), .snd_valid(snd_valid), .snd_tid(snd_tid), .fl_valid(fl_valid),
        .fl_tid(fl_tid), .fl_seq(fl_seq), .qry_tid(qry_tid), .qry_seq(qry_seq),
        .qry_live(o_live[0]), .qry_issue_ok(o_iss[0]), .qry_slot(o_qslot[0]));

    mq_slot_alloc #(.STORE_MODE(1'b0)) u_mq_slot_alloc_ld (
        .clk(clk), .rst(rst), .st_mode(st_mode), .dsp_req(dsp_req), .dsp_tid(dsp_tid),
        .dsp_cnt(dsp_cnt), .dsp_stall(o_stall[1]), .dsp_ok(o_ok[1]), .dsp_seq(o_seq[1]),
        .dsp_virt(o_virt[1]), .dsp_slot(o_slot[1]), .cmp_valid(cmp_valid), .cmp_tid(cmp_tid),
        .cmp_cnt(cmp_cnt), .snd_valid(snd_valid), .snd_tid(snd_tid), .fl_valid(fl_valid),
        .fl_tid(fl_tid), .fl_seq(fl_seq), .qry_tid(qry_tid), .qry_seq(qry_seq),
        .qry_live(o_live[1]), .qry_issue_ok(o_iss[1]), .qry_slot(o_qslot[1]));

    int n_chk = 0, n_bad = 0;
    // model state: [flavour 0 store / 1 load][thread]
    int hd [2][2], cm [2][2], tl [2][2];

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    function automatic int capf(input int t);
        if (st_mode) return (t == 0) ? 32 : 0;
        return 16;
    endfunction

    function automatic int occ(input int i, input int t);
        return (tl[i][t] - hd[i][t]) & 63;
    endfunction

    function automatic bit exp_stall(input int i);
        int t = int'(dsp_tid);
        if (!dsp_req) return 0;
        return (dsp_cnt == 3) || (st_mode && t == 1) || (fl_valid && fl_tid == dsp_tid)
            || (int'(dsp_cnt) > capf(t) + 16 - occ(i, t));
    endfunction

    function automatic int exp_slot(input int t, input int seq, input int pos);
        if (pos >= capf(t)) return seq % 16;
        if (st_mode) return seq % 32;
        return t * 16 + seq % 16;
    endfunction

    task automatic idle();
        dsp_req = 0; dsp_tid = 0; dsp_cnt = 0; cmp_valid = 0; cmp_tid = 0; cmp_cnt = 0;
        snd_valid = 0; snd_tid = 0; fl_valid = 0; fl_tid = 0; fl_seq = 0;
        qry_tid = 0; qry_seq = 0;
    endtask

    task automatic compare();
        #2;
        for (int i = 0; i < 2; i++) begin
            int t = int'(dsp_tid);
            bit es = exp_stall(i);
            int qt = int'(qry_tid);
            int pos = (int'(qry_seq) - hd[i][qt]) & 63;
            bit elive = pos < occ(i, qt);
            chk(o_stall[i] == es, "R4 stall", o_stall[i], es);
            for (int k = 0; k < 2; k++) begin
                bit eok = dsp_req && !es && (k < int'(dsp_cnt));
                chk(o_ok[i][k] == eok, "R4 grant", o_ok[i][k], eok);
                if (eok) begin
                    int sq = (tl[i][t] + k) & 63;
                    int p = occ(i, t) + k;
                    chk(int'(o_seq[i][k]) == sq, "R5 seq order", o_seq[i][k], sq);
                    chk(o_virt[i][k] == (p >= capf(t)), "R3 virtual mark", o_virt[i][k], p >= capf(t));
                    chk(int'(o_slot[i][k]) == exp_slot(t, sq, p), "R2 slot", o_slot[i][k], exp_slot(t, sq, p));
                end
            end
            chk(o_live[i] == elive, i == 0 ? "R6 live store" : "R5 live load", o_live[i], elive);
            chk(o_iss[i] == (elive && pos < capf(qt)), "R7 issue", o_iss[i], elive && pos < capf(qt));
            if (elive)
                chk(int'(o_qslot[i]) == exp_slot(qt, int'(qry_seq), pos), "R7 slot",
                    o_qslot[i], exp_slot(qt, int'(qry_seq), pos));
        end
    endtask

    task automatic commit();
        bit st [2];
        for (int i = 0; i < 2; i++) st[i] = exp_stall(i);
        for (int i = 0; i < 2; i++)
            for (int t = 0; t < 2; t++) begin
                int nh = hd[i][t], nc = cm[i][t], nt = tl[i][t];
                if (dsp_req && !st[i] && int'(dsp_tid) == t) nt = (nt + int'(dsp_cnt)) & 63;
                if (cmp_valid && int'(cmp_tid) == t) nc = (nc + int'(cmp_cnt)) & 63;
                if (i == 0) begin
                    if (snd_valid && int'(snd_tid) == t && cm[i][t] != hd[i][t]) nh = (nh + 1) & 63;
                end else nh = nc;
                if (fl_valid && int'(fl_tid) == t &&
                    ((int'(fl_seq) - cm[i][t]) & 63) <= ((tl[i][t] - cm[i][t]) & 63))
                    nt = int'(fl_seq);
                hd[i][t] = nh; cm[i][t] = nc; tl[i][t] = nt;
            end
    endtask

    task automatic do_reset(input bit st);
        @(negedge clk);
        idle(); rst = 1; st_mode = st;
        repeat (3) @(negedge clk);
        rst = 0;
        for (int i = 0; i < 2; i++)
            for (int t = 0; t < 2; t++) begin hd[i][t] = 0; cm[i][t] = 0; tl[i][t] = 0; end
    endtask

    function automatic int pmin(input int t);
        int a = (tl[0][t] - cm[0][t]) & 63;
        int b = (tl[1][t] - cm[1][t]) & 63;
        return a < b ? a : b;
    endfunction

    task automatic rand_cycles(input int n);
        for (int c = 0; c < n; c++) begin
            int rate = ((c / 200) % 2 == 0) ? 12 : 65;
            int ct;
            @(negedge clk);
            idle();
            dsp_req = ($urandom % 4) != 0;
            dsp_tid = st_mode ? (($urandom % 8) == 0) : 1'($urandom % 2);
            dsp_cnt = (($urandom % 10) == 0) ? 2'd3 : 2'($urandom % 3);
            ct = $urandom % 2;
            cmp_tid = 1'(ct);
            cmp_valid = ($urandom % 100) < rate;
            cmp_cnt = 2'((($urandom % 3) < pmin(ct)) ? ($urandom % 3) : pmin(ct));
            if (cmp_cnt > 2'(pmin(ct))) cmp_cnt = 2'(pmin(ct));
            snd_valid = ($urandom % 100) < rate;
            snd_tid = 1'($urandom % 2);
            if (($urandom % 40) == 0) begin
                int ft = $urandom % 2;
                fl_valid = 1; fl_tid = 1'(ft);
                fl_seq = 6'((cm[0][ft] + ($urandom % (pmin(ft) + 3))) & 63);
                if (cmp_valid && cmp_tid == fl_tid) cmp_valid = 0;
            end
            qry_tid = 1'($urandom % 2);
            qry_seq = 6'((hd[0][qry_tid] + ($urandom % 52)) & 63);
            compare();
            commit();
        end
    endtask

    // one directed cycle with current inputs
    task automatic dcyc();
        compare();
        commit();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; st_mode = 0; idle();
        do_reset(1'b0);

        // R1: empty after reset
        @(negedge clk); idle(); dsp_req = 1; dsp_cnt = 2; qry_seq = 0;
        #2;
        chk(!o_live[0] && !o_live[1], "R1 no live tag after reset", o_live[0], 0);
        chk(!o_stall[0], "R1 no stall after reset", o_stall[0], 0);
        chk(int'(o_slot[0][1]) == 1 && !o_virt[0][1], "R2 first slots real", o_slot[0][1], 1);
        dsp_req = 0;
        commit();

        // fill thread 0 to 32 entries: 16 real, 16 virtual
        for (int j = 0; j < 16; j++) begin
            @(negedge clk); idle(); dsp_req = 1; dsp_tid = 0; dsp_cnt = 2;
            #2;
            if (j == 8) chk(o_virt[0][0] && int'(o_slot[0][0]) == 0, "R3 op 16 virtual idx 0", o_slot[0][0], 0);
            commit();
        end
        @(negedge clk); idle(); dsp_req = 1; dsp_tid = 0; dsp_cnt = 1;
        #2;
        chk(o_stall[0] && o_ok[0] == 2'b00, "R4 stall at full", o_stall[0], 1);
        commit();
        @(negedge clk); idle(); dsp_req = 1; dsp_tid = 1; dsp_cnt = 2;
        #2;
        chk(!o_stall[0] && int'(o_slot[0][0]) == 16, "R10 thread 1 independent", o_slot[0][0], 16);
        commit();
        // sent with nothing completed: ignored
        @(negedge clk); idle(); snd_valid = 1; snd_tid = 0; dcyc();
        @(negedge clk); idle(); qry_seq = 0;
        #2;
        chk(o_live[0], "R6 idle sent ignored", o_live[0], 1);
        idle(); commit();
        // complete 2 oldest of thread 0
        @(negedge clk); idle(); cmp_valid = 1; cmp_tid = 0; cmp_cnt = 2; dcyc();
        @(negedge clk); idle(); qry_seq = 16;
        #2;
        chk(!o_iss[0], "R6 store waits for sent", o_iss[0], 0);
        chk(o_iss[1] && int'(o_qslot[1]) == 0, "R7 load promotes oldest virtual", o_qslot[1], 0);
        commit();
        @(negedge clk); idle(); snd_valid = 1; snd_tid = 0; dcyc();
        @(negedge clk); idle(); qry_seq = 16;
        #2;
        chk(o_iss[0] && int'(o_qslot[0]) == 0, "R7 store promoted after sent", o_qslot[0], 0);
        chk(!o_iss[0] || o_live[0], "R5 promoted tag live", o_live[0], 1);
        commit();
        // flush thread 0 at 20
        @(negedge clk); idle(); fl_valid = 1; fl_tid = 0; fl_seq = 20; dcyc();
        @(negedge clk); idle(); qry_seq = 25; dsp_req = 1; dsp_cnt = 1;
        #2;
        chk(!o_live[0], "R9 flushed tag gone", o_live[0], 0);
        chk(int'(o_seq[0][0]) == 20, "R9 restart at flush seq", o_seq[0][0], 20);
        commit();

        rand_cycles(3000);

        do_reset(1'b1);
        @(negedge clk); idle(); dsp_req = 1; dsp_tid = 1; dsp_cnt = 1;
        #2;
        chk(o_stall[0] && o_stall[1], "R8 thread 1 stalls", o_stall[0], 1);
        commit();
        for (int j = 0; j < 16; j++) begin
            @(negedge clk); idle(); dsp_req = 1; dsp_tid = 0; dsp_cnt = 2;
            #2;
            if (j == 15) chk(!o_virt[0][1] && int'(o_slot[0][1]) == 31, "R8 slot 31 real", o_slot[0][1], 31);
            commit();
        end
        @(negedge clk); idle(); dsp_req = 1; dsp_cnt = 1;
        #2;
        chk(o_virt[0][0] && int'(o_slot[0][0]) == 0, "R8 pos 32 virtual", o_slot[0][0], 0);
        commit();

        rand_cycles(3000);
        do_reset(1'b0);
        rand_cycles(1500);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule